// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns one asynchronous serial input line into parallel characters. The line rests high. A character begins with a low start bit and ends with a high stop bit. The receiver is clocked by the system clock and advances only on an oversample tick enable, which comes from an external integer divider. A falling edge seen at a tick starts the bit timer. Each bit is then resolved by a three-sample majority vote taken around the bit centre. The completed character is shown on a data port with a valid level, together with sticky status flags. A read-acknowledge pulse clears them.

The frame format is set at run time on static configuration inputs:

- the oversampling factor, from 4 to 32;
- a short (8-bit) or long (9-bit) character;
- LSB-first or MSB-first bit order;
- no parity, even parity or odd parity;
- inversion of the incoming line.

The status flags report:

- a bad stop bit;
- a parity mismatch;
- disagreeing samples inside a bit;
- a character lost because the previous one was not read;
- a quiet line lasting one character time after reception.

Configuration is expected to change only while no character is being received.

Top module: `uart_os_rx`

## Requirements
- R1: The line idles at 1. A 1-to-0 transition seen at an oversample tick starts a frame. The frame is start bit (0), data bits, optional parity bit, stop bit. When the stop bit is resolved, `rx_valid` goes to 1 and `rx_data` holds the character.
- R2: `cfg_osr_m1` holds the oversampling factor minus one, with legal values 3 to 31. One bit lasts factor ticks. Each bit is resolved around factor/2 ticks after its start, so data bit N is taken (N + 1.5) bit times after the start edge.
- R3: Each bit is the majority of three samples taken on consecutive ticks centred on mid-bit. If the three samples of any bit in a character disagree, `err_noise` is set with that character. The voted value is still used.
- R4: If the start bit votes 1 at its centre, the frame is dropped. No output or flag changes, and the next falling edge starts a new frame.
- R5: `cfg_nine`=0 selects 8 data bits, and `rx_data[8]` then reads 0. `cfg_nine`=1 selects 9 data bits.
- R6: `cfg_msb_first`=0 receives the least significant data bit first. `cfg_msb_first`=1 receives the most significant data bit first.
- R7: With `cfg_par_en`=1, a parity bit follows the data. `cfg_par_odd`=0 expects an even total count of ones over data plus parity, and `cfg_par_odd`=1 expects an odd total. A mismatch sets `err_parity`.
- R8: A stop bit that votes 0 sets `err_frame`. The character is still delivered.
- R9: If a character completes while `rx_valid` is 1 and no acknowledge is given, `err_overrun` is set. `rx_data` and the other flags keep the earlier character's values.
- R10: After a frame has completed, `idle_flag` is set once the line has stayed 1 for one full character time of ticks. A character time is (frame bits × factor). It is not set again until another frame completes.
- R11: `cfg_invert`=1 inverts the line before start detection and sampling.
- R12: A one-cycle `rd_ack` clears `rx_valid`, `err_frame`, `err_parity`, `err_noise`, `err_overrun` and `idle_flag`. After reset all of these are 0 and `rx_data` is 0.
- R13: All bit timing counts `os_tick` pulses and not clock cycles. A tick every third clock gives bits three times as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversample tick enable from the rate divider |
| rx_line | input | 1 | Asynchronous serial input line |
| cfg_osr_m1 | input | 5 | Oversampling factor minus one (3..31) |
| cfg_nine | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| cfg_msb_first | input | 1 | 1 receives the most significant bit first |
| cfg_par_en | input | 1 | 1 expects a parity bit after the data |
| cfg_par_odd | input | 1 | 1 odd parity, 0 even parity |
| cfg_invert | input | 1 | 1 inverts the incoming line |
| rd_ack | input | 1 | Read acknowledge, clears valid and all flags |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | Character waiting to be read |
| err_frame | output | 1 | Stop bit was 0 |
| err_parity | output | 1 | Parity mismatch |
| err_noise | output | 1 | Samples within a bit disagreed |
| err_overrun | output | 1 | A character was lost while one was unread |
| idle_flag | output | 1 | Line quiet for one character time after a frame |

## Verification
The bench drives a one-tick glitch onto the centre sample of a data bit and onto the centre sample of the start bit. A receiver that uses a single sample would return a corrupted byte or drop the frame. A receiver with a broken vote would miss the noise flag.

A start pulse two ticks long checks the false-start path. A design without that check would deliver a phantom character.

Back-to-back frames without an acknowledge check the overrun path. A design that overwrites on overrun would show the second byte.

The extremes of the oversampling range, MSB-first long characters, a flipped parity bit, a zero stop bit, inversion and a slowed tick are each checked. These cases would expose off-by-one bit timing, a reversed index, inverted parity sense, or a design that counts clocks rather than ticks.

// File: rtl/uart_os_rx_pkg.sv
// Shared types for the oversampling serial receiver.
package uart_os_rx_pkg;

    // Frame sequencer position.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_t;

endpackage

// File: rtl/uart_os_rx_front.sv
// Line front end: synchronises the asynchronous input, applies optional
// inversion and flags a 1-to-0 transition seen at an oversample tick.
// Assumes SYNC_STAGES >= 2. The synchroniser resets to the idle level.
module uart_os_rx_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic invert,
    input  logic tick,
    output logic sample_o,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
    end

    assign sample_o = sync_q[SYNC_STAGES-1] ^ invert;

    // Remember the level seen at the previous tick for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_q <= 1'b1;
        else if (tick) prev_q <= sample_o;
    end

    assign fall_o = tick & prev_q & ~sample_o;

endmodule

// File: rtl/uart_os_rx_voter.sv
// Three-sample majority voter. It captures the samples at ticks half-1 and
// half of the bit, then resolves at tick half+1 using the live sample.
// Assumes half >= 2, which holds for oversampling factors of 4 and more.
module uart_os_rx_voter #(
    parameter int OSR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sample,
    input  logic [OSR_W-1:0] phase,
    input  logic [OSR_W-1:0] half,
    output logic             vote_done,
    output logic             vote_bit,
    output logic             vote_noisy
);

    logic early_q;
    logic centre_q;

    // Capture the two samples that precede the deciding tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            early_q  <= 1'b1;
            centre_q <= 1'b1;
        end else if (tick) begin
            if (phase == half - OSR_W'(1)) early_q  <= sample;
            if (phase == half)             centre_q <= sample;
        end
    end

    // Resolve majority and disagreement at the third sample.
    always_comb begin
        vote_done  = tick && (phase == half + OSR_W'(1));
        vote_bit   = (early_q & centre_q) | (early_q & sample) | (centre_q & sample);
        vote_noisy = !((early_q == centre_q) && (centre_q == sample));
    end

endmodule

// File: rtl/uart_os_rx_frame.sv
// Frame sequencer: runs the in-bit tick counter and walks start, data,
// parity and stop. It assembles the character in the chosen bit order and
// emits a one-cycle completion pulse with the per-character error results.
// Assumes configuration is stable while a frame is in progress.
module uart_os_rx_frame
    import uart_os_rx_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int OSR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fall,
    input  logic              vote_done,
    input  logic              vote_bit,
    input  logic              vote_noisy,
    input  logic [OSR_W-1:0]  cfg_osr_m1,
    input  logic              cfg_nine,
    input  logic              cfg_msb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    output logic [OSR_W-1:0]  phase_o,
    output logic [OSR_W-1:0]  half_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              fe_o,
    output logic              pe_o,
    output logic              ne_o
);

    localparam int IDX_W = $clog2(DATA_W);

    rx_state_t         state_q;
    logic [OSR_W-1:0]  phase_q;
    logic [IDX_W-1:0]  bit_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic              noise_q;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  wr_idx;

    // Mid-bit tick (factor / 2), last data index and write position.
    always_comb begin
        half_o   = OSR_W'(cfg_osr_m1 >> 1) + OSR_W'(cfg_osr_m1[0]);
        last_idx = cfg_nine ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
        wr_idx   = cfg_msb_first ? (last_idx - bit_q) : bit_q;
    end

    assign phase_o = phase_q;
    assign busy_o  = (state_q != ST_IDLE);

    // Sequence the frame one voted bit at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            bit_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
            noise_q <= 1'b0;
            done_o  <= 1'b0;
            data_o  <= '0;
            fe_o    <= 1'b0;
            pe_o    <= 1'b0;
            ne_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state_q == ST_IDLE) begin
                phase_q <= '0;
                if (fall) begin
                    state_q <= ST_START;
                    phase_q <= OSR_W'(1);
                    bit_q   <= '0;
                    shift_q <= '0;
                    par_q   <= 1'b0;
                    noise_q <= 1'b0;
                end
            end else begin
                if (tick)
                    phase_q <= (phase_q == cfg_osr_m1) ? '0 : phase_q + OSR_W'(1);
                if (vote_done) begin
                    unique case (state_q)
                        ST_START: begin
                            if (vote_bit) begin
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_DATA;
                                noise_q <= vote_noisy;
                            end
                        end
                        ST_DATA: begin
                            shift_q[wr_idx] <= vote_bit;
                            par_q   <= par_q ^ vote_bit;
                            noise_q <= noise_q | vote_noisy;
                            bit_q   <= bit_q + IDX_W'(1);
                            if (bit_q == last_idx)
                                state_q <= cfg_par_en ? ST_PAR : ST_STOP;
                        end
                        ST_PAR: begin
                            par_q   <= par_q ^ vote_bit;
                            noise_q <= noise_q | vote_noisy;
                            state_q <= ST_STOP;
                        end
                        ST_STOP: begin
                            state_q <= ST_IDLE;
                            done_o  <= 1'b1;
                            data_o  <= shift_q;
                            fe_o    <= ~vote_bit;
                            pe_o    <= cfg_par_en & (par_q ^ cfg_par_odd);
                            ne_o    <= noise_q | vote_noisy;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    AST_START_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) == ST_IDLE) |-> $past(fall)); // R1
    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= cfg_osr_m1); // R2
    AST_FALSE_START_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && vote_done && vote_bit) |=> (state_q == ST_IDLE && !done_o)); // R4

endmodule

// File: rtl/uart_os_rx_status.sv
// Output holding and status: loads completed characters, detects overrun,
// counts quiet ticks for the idle indication and clears on acknowledge.
// Assumes done_i is a single-cycle pulse and char_ticks >= 2.
module uart_os_rx_status #(
    parameter int DATA_W = 9,
    parameter int CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              fe_i,
    input  logic              pe_i,
    input  logic              ne_i,
    input  logic              ack_i,
    input  logic [CNT_W-1:0]  char_ticks,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_noise,
    output logic              err_overrun,
    output logic              idle_flag
);

    logic             keep;
    logic             armed_q;
    logic [CNT_W-1:0] quiet_q;

    assign keep = rx_valid & ~ack_i;

    // Hold the character and its flags, flag overrun, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_valid    <= 1'b0;
            err_frame   <= 1'b0;
            err_parity  <= 1'b0;
            err_noise   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (ack_i) begin
                rx_valid    <= 1'b0;
                err_frame   <= 1'b0;
                err_parity  <= 1'b0;
                err_noise   <= 1'b0;
                err_overrun <= 1'b0;
            end
            if (done_i) begin
                if (keep) begin
                    err_overrun <= 1'b1;
                end else begin
                    rx_data    <= data_i;
                    rx_valid   <= 1'b1;
                    err_frame  <= fe_i;
                    err_parity <= pe_i;
                    err_noise  <= ne_i;
                end
            end
        end
    end

    // Count quiet ticks after a frame and raise the idle indication once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            quiet_q   <= '0;
            idle_flag <= 1'b0;
        end else begin
            if (ack_i) idle_flag <= 1'b0;
            if (done_i) begin
                armed_q <= 1'b1;
                quiet_q <= '0;
            end else if (busy_i) begin
                quiet_q <= '0;
            end else if (tick && armed_q) begin
                if (!line_i) begin
                    quiet_q <= '0;
                end else if (quiet_q == char_ticks - CNT_W'(1)) begin
                    idle_flag <= 1'b1;
                    armed_q   <= 1'b0;
                    quiet_q   <= '0;
                end else begin
                    quiet_q <= quiet_q + CNT_W'(1);
                end
            end
        end
    end

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ack_i) |=> (rx_valid && $stable(rx_data))); // R9
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !ack_i && done_i) |=> err_overrun); // R9
    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !done_i) |=> !(rx_valid || err_frame || err_parity || err_noise || err_overrun)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> $past(line_i && !busy_i)); // R10

endmodule

// File: rtl/uart_os_rx.sv
// Oversampling asynchronous serial receiver top: joins the line front end,
// majority voter, frame sequencer and status holder, and derives the
// character time used for idle detection.
// Assumes os_tick comes from an external divider at factor x bit rate.
module uart_os_rx #(
    parameter int DATA_W      = 9,
    parameter int OSR_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_line,
    input  logic [OSR_W-1:0]  cfg_osr_m1,
    input  logic              cfg_nine,
    input  logic              cfg_msb_first,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_invert,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_frame,
    output logic              err_parity,
    output logic              err_noise,
    output logic              err_overrun,
    output logic              idle_flag
);

    localparam int MAX_FRAME = DATA_W + 3;
    localparam int CNT_W     = $clog2(MAX_FRAME * (2 ** OSR_W) + 1);

    logic              sample;
    logic              fall;
    logic [OSR_W-1:0]  phase;
    logic [OSR_W-1:0]  half;
    logic              vote_done;
    logic              vote_bit;
    logic              vote_noisy;
    logic              busy;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_fe;
    logic              frm_pe;
    logic              frm_ne;
    logic [CNT_W-1:0]  char_ticks;

    // Character time in ticks: (start + data + parity + stop) x factor.
    always_comb begin
        char_ticks = (CNT_W'(DATA_W + 1) + CNT_W'(cfg_nine) + CNT_W'(cfg_par_en))
                   * (CNT_W'(cfg_osr_m1) + CNT_W'(1));
    end

    uart_os_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (rx_line),
        .invert   (cfg_invert),
        .tick     (os_tick),
        .sample_o (sample),
        .fall_o   (fall)
    );

    uart_os_rx_voter #(.OSR_W(OSR_W)) u_voter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (os_tick),
        .sample     (sample),
        .phase      (phase),
        .half       (half),
        .vote_done  (vote_done),
        .vote_bit   (vote_bit),
        .vote_noisy (vote_noisy)
    );

    uart_os_rx_frame #(.DATA_W(DATA_W), .OSR_W(OSR_W)) u_frame (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (os_tick),
        .fall          (fall),
        .vote_done     (vote_done),
        .vote_bit      (vote_bit),
        .vote_noisy    (vote_noisy),
        .cfg_osr_m1    (cfg_osr_m1),
        .cfg_nine      (cfg_nine),
        .cfg_msb_first (cfg_msb_first),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_odd   (cfg_par_odd),
        .phase_o       (phase),
        .half_o        (half),
        .busy_o        (busy),
        .done_o        (frm_done),
        .data_o        (frm_data),
        .fe_o          (frm_fe),
        .pe_o          (frm_pe),
        .ne_o          (frm_ne)
    );

    uart_os_rx_status #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (os_tick),
        .line_i      (sample),
        .busy_i      (busy),
        .done_i      (frm_done),
        .data_i      (frm_data),
        .fe_i        (frm_fe),
        .pe_i        (frm_pe),
        .ne_i        (frm_ne),
        .ack_i       (rd_ack),
        .char_ticks  (char_ticks),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .err_frame   (err_frame),
        .err_parity  (err_parity),
        .err_noise   (err_noise),
        .err_overrun (err_overrun),
        .idle_flag   (idle_flag)
    );

endmodule

// File: tb/uart_os_rx_tb.sv
// Bench for the oversampling receiver. A behavioural line driver builds
// each frame from the requirements. The expected character and flags are
// computed here. A per-clock monitor checks that held data never moves.
module uart_os_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       rd_ack = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, err_frame, err_parity, err_noise, err_overrun, idle_flag;

    int osr_i = 16;
    int div_i = 1;
    bit inv_b = 1'b0, nine_b = 1'b0, msb_b = 1'b0, pen_b = 1'b0, podd_b = 1'b0;
    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;
    bit done_flag = 1'b0;

    logic [4:0] cfg_osr_m1;
    assign cfg_osr_m1 = 5'(osr_i - 1);

    always #4 clk = ~clk;

    uart_os_rx u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .os_tick       (os_tick),
        .rx_line       (rx_line),
        .cfg_osr_m1    (cfg_osr_m1),
        .cfg_nine      (nine_b),
        .cfg_msb_first (msb_b),
        .cfg_par_en    (pen_b),
        .cfg_par_odd   (podd_b),
        .cfg_invert    (inv_b),
        .rd_ack        (rd_ack),
        .rx_data       (rx_data),
        .rx_valid      (rx_valid),
        .err_frame     (err_frame),
        .err_parity    (err_parity),
        .err_noise     (err_noise),
        .err_overrun   (err_overrun),
        .idle_flag     (idle_flag)
    );

    // Tick generator: one tick every div_i clocks, driven at the falling edge.
    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1 >= div_i) ? 0 : tick_cnt + 1;
        os_tick  = (tick_cnt == 0);
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Per-clock model comparison: held data stays put until acknowledged (R9).
    logic [8:0] mon_data;
    bit         mon_hold = 1'b0;
    always @(negedge clk) begin
        #1;
        if (rst_n && mon_hold) chk("R9", "held data moved", int'(rx_data), int'(mon_data));
        mon_hold = rst_n && rx_valid && !rd_ack;
        mon_data = rx_data;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    // Drive one frame. glitch_bit is a frame position (0 = start) that gets
    // one inverted tick at its centre; -1 disables the glitch.
    task automatic send_frame(input logic [8:0] d, input bit par_flip,
                              input bit stop_v, input int glitch_bit);
        bit fb[12];
        int n = 0;
        int nb = nine_b ? 9 : 8;
        bit px = 1'b0;
        fb[n++] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            int idx = msb_b ? (nb - 1 - i) : i;
            fb[n++] = d[idx];
            px ^= d[i];
        end
        if (pen_b) fb[n++] = px ^ podd_b ^ par_flip;
        fb[n++] = stop_v;
        for (int k = 0; k < n; k++) begin
            for (int c = 0; c < osr_i * div_i; c++) begin
                bit v = fb[k];
                @(negedge clk);
                if (k == glitch_bit && (c / div_i) == osr_i / 2) v = ~v;
                rx_line = v ^ inv_b;
            end
        end
        @(negedge clk) rx_line = ~inv_b;
    endtask

    task automatic chk_rx(input string tag, input int d, input bit fe, input bit pe,
                          input bit ne, input bit ovr);
        wait_clk(4);
        chk(tag, "rx_valid", int'(rx_valid), 1);
        chk(tag, "rx_data", int'(rx_data), d);
        chk(tag, "err_frame", int'(err_frame), int'(fe));
        chk(tag, "err_parity", int'(err_parity), int'(pe));
        chk(tag, "err_noise", int'(err_noise), int'(ne));
        chk(tag, "err_overrun", int'(err_overrun), int'(ovr));
        chk(tag, "idle_flag", int'(idle_flag), 0);
    endtask

    task automatic chk_clear(input string tag);
        chk(tag, "valid after ack", int'(rx_valid), 0);
        chk(tag, "flags after ack",
            int'({err_frame, err_parity, err_noise, err_overrun, idle_flag}), 0);
    endtask

    task automatic frame_ok(input string tag, input logic [8:0] d);
        send_frame(d, 1'b0, 1'b1, -1);
        chk_rx(tag, int'(d), 1'b0, 1'b0, 1'b0, 1'b0);
        ack();
    endtask

    initial begin
        wait_clk(5);
        @(negedge clk) rst_n = 1'b1;
        wait_clk(2);
        // R12: reset state
        chk("R12", "reset valid", int'(rx_valid), 0);
        chk("R12", "reset data", int'(rx_data), 0);
        chk_clear("R12");

        // R1 / R6: basic LSB-first 8-bit frame
        frame_ok("R1", 9'h04B);
        frame_ok("R6", 9'h0C5);
        // R2: smallest and largest oversampling factors
        osr_i = 4;  wait_clk(4); frame_ok("R2", 9'h03C);
        osr_i = 32; wait_clk(4); frame_ok("R2", 9'h0C1);
        osr_i = 16; wait_clk(4);
        // R5: 9-bit characters, then bit 8 reads 0 in 8-bit mode
        nine_b = 1'b1; frame_ok("R5", 9'h1C6);
        nine_b = 1'b0; frame_ok("R5", 9'h0FF);
        // R6: MSB first, 8 and 9 bits
        msb_b = 1'b1; frame_ok("R6", 9'h02D);
        nine_b = 1'b1; frame_ok("R6", 9'h10E);
        msb_b = 1'b0; nine_b = 1'b0;
        // R7: even, odd and corrupted parity
        pen_b = 1'b1; podd_b = 1'b0; frame_ok("R7", 9'h05A);
        podd_b = 1'b1; frame_ok("R7", 9'h05B);
        send_frame(9'h05B, 1'b1, 1'b1, -1);
        chk_rx("R7", 'h05B, 1'b0, 1'b1, 1'b0, 1'b0);
        ack();
        chk_clear("R12");
        pen_b = 1'b0; podd_b = 1'b0;
        // R8: stop bit low, data still delivered
        send_frame(9'h077, 1'b0, 1'b0, -1);
        chk_rx("R8", 'h077, 1'b1, 1'b0, 1'b0, 1'b0);
        ack();
        chk_clear("R12");
        wait_clk(4);
        // R3: glitch on a data-bit centre and on the start-bit centre
        send_frame(9'h00F, 1'b0, 1'b1, 4);
        chk_rx("R3", 'h00F, 1'b0, 1'b0, 1'b1, 1'b0);
        ack();
        send_frame(9'h0A3, 1'b0, 1'b1, 0);
        chk_rx("R3", 'h0A3, 1'b0, 1'b0, 1'b1, 1'b0);
        ack();
        // R9: second character arrives unread
        send_frame(9'h011, 1'b0, 1'b1, -1);
        chk_rx("R9", 'h011, 1'b0, 1'b0, 1'b0, 1'b0);
        send_frame(9'h022, 1'b0, 1'b1, -1);
        chk_rx("R9", 'h011, 1'b0, 1'b0, 1'b0, 1'b1);
        ack();
        chk_clear("R12");
        // R10: idle after one character time of quiet line
        osr_i = 8; wait_clk(4);
        send_frame(9'h033, 1'b0, 1'b1, -1);
        chk_rx("R10", 'h033, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_clk(10 * 8 + 20);
        chk("R10", "idle set", int'(idle_flag), 1);
        ack();
        chk_clear("R12");
        wait_clk(200);
        chk("R10", "idle not re-raised without a frame", int'(idle_flag), 0);
        // R4: short low pulse is a false start
        osr_i = 16; wait_clk(4);
        @(negedge clk) rx_line = 1'b0;
        wait_clk(2);
        rx_line = 1'b1;
        wait_clk(20 * 16);
        chk("R4", "no character from false start", int'(rx_valid), 0);
        chk("R4", "no flags from false start", int'({err_frame, err_noise, idle_flag}), 0);
        frame_ok("R4", 9'h06E);
        // R11: inverted line
        inv_b = 1'b1; rx_line = 1'b0; wait_clk(3 * 16);
        ack();
        frame_ok("R11", 9'h09C);
        inv_b = 1'b0; rx_line = 1'b1; wait_clk(3 * 16);
        ack();
        // R13: tick every third clock
        div_i = 3; osr_i = 4; wait_clk(12);
        frame_ok("R13", 9'h0E4);
        div_i = 1; wait_clk(4);

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule